// File: doc/BRIEF.md
# Shared-Sense-Amp Bank State Tracker

This block sits on the controller side of a DRAM channel and keeps a shadow of which banks of a 32-bank device hold an open row, and which row that is. The device's sense amps are shared between neighbouring banks, so two banks that share a sense amp can never be open together. The one exception is the boundary between banks 15 and 16, which has no shared sense amp. The outermost banks 0 and 31 have only one neighbour each.

Already decoded commands come in one per cycle. Each carries an opcode, a bank, a row and a byte-mask flag. One cycle later the block reports whether the command was legal, and the open flags and stored rows reflect its effect. Precharge can arrive in three ways: as a row precharge, as a column operation with auto-precharge, or as an extended-operation precharge. The extended form is only valid straight after a read, or after a write without byte masking. A query port returns the row stored for any bank.

Top module: `bank_state_tracker`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, every bank open flag is 0 and rsp_valid is 0.
- R2: An activate (cmd_op 0) to an idle bank with no open sharing neighbour is legal. The bank's open flag is set and query_row returns cmd_row for that bank.
- R3: An activate to a bank whose sharing neighbour (bank-1 or bank+1, excluding the 15/16 boundary) is open is illegal and changes no open flag.
- R4: Banks 15 and 16 may be open together, and banks 0 and 31 are checked against their single neighbour only.
- R5: An activate to a bank that is already open is illegal and leaves both the open flags and the stored row unchanged.
- R6: A row precharge (cmd_op 1) is always legal and clears the bank's open flag. On an idle bank it does nothing, and afterwards the bank or its neighbours can be activated.
- R7: A read (cmd_op 2) or write (cmd_op 3) is legal only when its bank is open, and it never changes the open flags.
- R8: Read with auto-precharge (cmd_op 4) and write with auto-precharge (cmd_op 5) are legal only on an open bank and, when legal, close it. A no-column-operation with precharge (cmd_op 6) is always legal and closes the bank.
- R9: An extended precharge (cmd_op 7) is legal only when the previous command was a legal read (op 2 or 4) or a legal write (op 3 or 5) with cmd_masked = 0. When legal it closes its bank; when illegal it changes nothing.
- R10: rsp_valid is 1 exactly in the cycle after a cycle with cmd_valid = 1. A cycle without cmd_valid changes no open flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_op | input | 3 | Opcode: 0 act, 1 row pre, 2 rd, 3 wr, 4 rd+pre, 5 wr+pre, 6 nocop+pre, 7 ext pre |
| cmd_bank | input | 5 | Target bank |
| cmd_row | input | 9 | Row for an activate |
| cmd_masked | input | 1 | Write uses byte masking |
| query_bank | input | 5 | Bank whose stored row is returned |
| rsp_valid | output | 1 | Verdict for the previous cycle's command |
| rsp_legal | output | 1 | That command was legal |
| bank_open | output | 32 | Per-bank open flags |
| query_row | output | 9 | Stored row of query_bank |

## Verification
A wrong open flag shows up directly on bank_open one cycle after the command that set it wrongly. It also shows up later as a wrong verdict on the next activate to that bank or its neighbours, or on a column access to it. A stale extended-precharge permission appears only on the command right after the one that should have revoked it, so the stimulus places extended precharges right after masked writes, failed reads and row precharges. A wrongly stored row appears on query_row after the activate, and also after a rejected re-activate that must not overwrite it.

// File: rtl/bst_pkg.sv
package bst_pkg;
    typedef enum logic [2:0] {
        OP_ACT  = 3'd0,
        OP_PRE  = 3'd1,
        OP_RD   = 3'd2,
        OP_WR   = 3'd3,
        OP_RDP  = 3'd4,
        OP_WRP  = 3'd5,
        OP_NOPP = 3'd6,
        OP_XPRE = 3'd7
    } bst_op_e;
endpackage

// File: rtl/bst_share_map.sv
module bst_share_map #(
    parameter int NUM_BANKS = 32,
    parameter int SPLIT     = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_BANKS-1:0] open_vec,
    output logic [NUM_BANKS-1:0] blocked
);
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam bit HAS_LO = (b > 0) && (b != SPLIT);
        localparam bit HAS_HI = (b < NUM_BANKS - 1) && (b + 1 != SPLIT);
        if (HAS_LO && HAS_HI) begin : g_both
            assign blocked[b] = open_vec[b-1] | open_vec[b+1];
        end else if (HAS_LO) begin : g_lo
            assign blocked[b] = open_vec[b-1];
        end else if (HAS_HI) begin : g_hi
            assign blocked[b] = open_vec[b+1];
        end else begin : g_none
            assign blocked[b] = 1'b0;
        end

        if (HAS_HI) begin : g_pair_chk
            // R3
            no_shared_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !(open_vec[b] && open_vec[b+1]));
        end
    end
endmodule

// File: rtl/bst_row_store.sv
module bst_row_store #(
    parameter int NUM_BANKS = 32,
    parameter int ROW_W     = 9,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BANK_W-1:0] wr_bank,
    input  logic [ROW_W-1:0]  wr_row,
    input  logic [BANK_W-1:0] rd_bank,
    output logic [ROW_W-1:0]  rd_row
);
    logic [ROW_W-1:0] rows_d [NUM_BANKS];
    logic [ROW_W-1:0] rows_q [NUM_BANKS];

    always_comb begin
        rows_d = rows_q;
        if (wr_en) rows_d[wr_bank] = wr_row;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_BANKS; i++) rows_q[i] <= '0;
        end else begin
            rows_q <= rows_d;
        end
    end

    assign rd_row = rows_q[rd_bank];
endmodule

// File: rtl/bank_state_tracker.sv
module bank_state_tracker #(
    parameter int NUM_BANKS = 32,
    parameter int ROW_W     = 9,
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int SPLIT    = NUM_BANKS / 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic [2:0]           cmd_op,
    input  logic [BANK_W-1:0]    cmd_bank,
    input  logic [ROW_W-1:0]     cmd_row,
    input  logic                 cmd_masked,
    input  logic [BANK_W-1:0]    query_bank,
    output logic                 rsp_valid,
    output logic                 rsp_legal,
    output logic [NUM_BANKS-1:0] bank_open,
    output logic [ROW_W-1:0]     query_row
);
    import bst_pkg::*;

    typedef struct packed {
        logic [NUM_BANKS-1:0] open;
        logic                 xop_ok;
        logic                 rsp_valid;
        logic                 rsp_legal;
    } trk_state_t;

    trk_state_t st_d, st_q;
    logic [NUM_BANKS-1:0] blocked;
    logic                 legal;
    logic                 row_we;
    bst_op_e              op;

    assign op = bst_op_e'(cmd_op);

    bst_share_map #(.NUM_BANKS(NUM_BANKS), .SPLIT(SPLIT)) u_share (
        .clk     (clk),
        .rst_n   (rst_n),
        .open_vec(st_q.open),
        .blocked (blocked)
    );

    always_comb begin
        logic is_open;
        st_d    = st_q;
        is_open = st_q.open[cmd_bank];
        legal   = 1'b0;
        row_we  = 1'b0;
        st_d.rsp_valid = cmd_valid;
        if (cmd_valid) begin
            case (op)
                OP_ACT: begin
                    legal = !is_open && !blocked[cmd_bank];
                    if (legal) begin
                        st_d.open[cmd_bank] = 1'b1;
                        row_we = 1'b1;
                    end
                end
                OP_PRE, OP_NOPP: begin
                    legal = 1'b1;
                    st_d.open[cmd_bank] = 1'b0;
                end
                OP_RD, OP_WR: legal = is_open;
                OP_RDP, OP_WRP: begin
                    legal = is_open;
                    if (legal) st_d.open[cmd_bank] = 1'b0;
                end
                OP_XPRE: begin
                    legal = st_q.xop_ok;
                    if (legal) st_d.open[cmd_bank] = 1'b0;
                end
                default: legal = 1'b0;
            endcase
            st_d.rsp_legal = legal;
            st_d.xop_ok = legal && ((op == OP_RD) || (op == OP_RDP) ||
                          (((op == OP_WR) || (op == OP_WRP)) && !cmd_masked));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    bst_row_store #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)) u_rows (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (row_we),
        .wr_bank(cmd_bank),
        .wr_row (cmd_row),
        .rd_bank(query_bank),
        .rd_row (query_row)
    );

    assign rsp_valid = st_q.rsp_valid;
    assign rsp_legal = st_q.rsp_legal;
    assign bank_open = st_q.open;

    // R3
    act_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd0 && blocked[cmd_bank]) |=> (!rsp_legal && $stable(bank_open)));
    // R5
    act_reopen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd0 && bank_open[cmd_bank]) |=> (!rsp_legal && $stable(bank_open)));
    // R6
    pre_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd1) |=> (rsp_legal && !bank_open[$past(cmd_bank)]));
    // R7
    col_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_op == 3'd2 || cmd_op == 3'd3)) |=> $stable(bank_open));
    // R10
    rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> rsp_valid);
    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> (!rsp_valid && $stable(bank_open)));
endmodule

// File: tb/tb_bank_state_tracker.sv
module tb_bank_state_tracker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [4:0]  cmd_bank = '0;
    logic [8:0]  cmd_row = '0;
    logic        cmd_masked = 1'b0;
    logic [4:0]  query_bank = '0;
    logic        rsp_valid, rsp_legal;
    logic [31:0] bank_open;
    logic [8:0]  query_row;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bank_state_tracker dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_masked(cmd_masked),
        .query_bank(query_bank), .rsp_valid(rsp_valid), .rsp_legal(rsp_legal),
        .bank_open(bank_open), .query_row(query_row)
    );

    // {req4, op3, bank5, row9, masked1, exp_legal1, exp_open1}
    localparam int NV = 28;
    localparam logic [23:0] VEC [NV] = '{
        {4'd2, 3'd0, 5'd5,  9'd10, 1'b0, 1'b1, 1'b1},
        {4'd3, 3'd0, 5'd6,  9'd11, 1'b0, 1'b0, 1'b0},
        {4'd3, 3'd0, 5'd4,  9'd12, 1'b0, 1'b0, 1'b0},
        {4'd5, 3'd0, 5'd5,  9'd20, 1'b0, 1'b0, 1'b1},
        {4'd7, 3'd2, 5'd5,  9'd0,  1'b0, 1'b1, 1'b1},
        {4'd9, 3'd7, 5'd5,  9'd0,  1'b0, 1'b1, 1'b0},
        {4'd7, 3'd2, 5'd5,  9'd0,  1'b0, 1'b0, 1'b0},
        {4'd9, 3'd7, 5'd5,  9'd0,  1'b0, 1'b0, 1'b0},
        {4'd2, 3'd0, 5'd15, 9'd1,  1'b0, 1'b1, 1'b1},
        {4'd4, 3'd0, 5'd16, 9'd2,  1'b0, 1'b1, 1'b1},
        {4'd3, 3'd0, 5'd14, 9'd3,  1'b0, 1'b0, 1'b0},
        {4'd3, 3'd0, 5'd17, 9'd3,  1'b0, 1'b0, 1'b0},
        {4'd7, 3'd3, 5'd16, 9'd0,  1'b1, 1'b1, 1'b1},
        {4'd9, 3'd7, 5'd16, 9'd0,  1'b0, 1'b0, 1'b1},
        {4'd7, 3'd3, 5'd16, 9'd0,  1'b0, 1'b1, 1'b1},
        {4'd9, 3'd7, 5'd16, 9'd0,  1'b0, 1'b1, 1'b0},
        {4'd6, 3'd1, 5'd16, 9'd0,  1'b0, 1'b1, 1'b0},
        {4'd8, 3'd5, 5'd15, 9'd0,  1'b0, 1'b1, 1'b0},
        {4'd8, 3'd4, 5'd15, 9'd0,  1'b0, 1'b0, 1'b0},
        {4'd4, 3'd0, 5'd0,  9'd3,  1'b0, 1'b1, 1'b1},
        {4'd4, 3'd0, 5'd31, 9'd4,  1'b0, 1'b1, 1'b1},
        {4'd3, 3'd0, 5'd1,  9'd5,  1'b0, 1'b0, 1'b0},
        {4'd3, 3'd0, 5'd30, 9'd6,  1'b0, 1'b0, 1'b0},
        {4'd8, 3'd6, 5'd0,  9'd0,  1'b0, 1'b1, 1'b0},
        {4'd6, 3'd0, 5'd1,  9'd7,  1'b0, 1'b1, 1'b1},
        {4'd6, 3'd1, 5'd31, 9'd0,  1'b0, 1'b1, 1'b0},
        {4'd9, 3'd7, 5'd1,  9'd0,  1'b0, 1'b0, 1'b1},
        {4'd8, 3'd4, 5'd1,  9'd0,  1'b0, 1'b1, 1'b0}
    };

    function automatic string tag(input logic [3:0] r);
        case (r)
            4'd2: return "R2";
            4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            4'd8: return "R8";
            4'd9: return "R9";
            default: return "R?";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // called just after a falling edge; returns at the next falling edge
    task automatic issue(input logic [2:0] op, input logic [4:0] bank,
                         input logic [8:0] row, input logic masked);
        cmd_valid = 1'b1; cmd_op = op; cmd_bank = bank;
        cmd_row = row; cmd_masked = masked;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 open during reset", bank_open, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 open after reset", bank_open, 32'h0);
        check("R1 rsp_valid after reset", {31'h0, rsp_valid}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            logic [23:0] v;
            v = VEC[i];
            issue(v[19:17], v[16:12], v[11:3], v[2]);
            check({tag(v[23:20]), " rsp_valid"}, {31'h0, rsp_valid}, 32'h1);
            check({tag(v[23:20]), " legal"}, {31'h0, rsp_legal}, {31'h0, v[1]});
            check({tag(v[23:20]), " open flag"}, {31'h0, bank_open[v[16:12]]}, {31'h0, v[0]});
        end
        check("R6 all closed after table", bank_open, 32'h0);

        // R2 stored row
        issue(3'd0, 5'd10, 9'h1AB, 1'b0);
        query_bank = 5'd10;
        #1;
        check("R2 query_row", {23'h0, query_row}, 32'h1AB);
        check("R2 open vector", bank_open, 32'h0000_0400);

        // R5 re-activate keeps row
        issue(3'd0, 5'd10, 9'h005, 1'b0);
        #1;
        check("R5 legal", {31'h0, rsp_legal}, 32'h0);
        check("R5 row kept", {23'h0, query_row}, 32'h1AB);

        // R10 idle cycle
        @(negedge clk);
        check("R10 no rsp when idle", {31'h0, rsp_valid}, 32'h0);
        check("R10 state held when idle", bank_open, 32'h0000_0400);

        // R9 extended precharge right after a legal read with auto-precharge
        issue(3'd0, 5'd20, 9'd9, 1'b0);
        issue(3'd4, 5'd20, 9'd0, 1'b0);
        issue(3'd7, 5'd10, 9'd0, 1'b0);
        check("R9 xpre after rd+pre legal", {31'h0, rsp_legal}, 32'h1);
        check("R9 xpre closed bank", bank_open, 32'h0);

        // R1 reset mid-run
        issue(3'd0, 5'd3, 9'd1, 1'b0);
        rst_n = 1'b0;
        #1;
        check("R1 reset clears", bank_open, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        query_bank = 5'd3;
        #1;
        check("R1 rows cleared", {23'h0, query_row}, 32'h0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule